// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block is a bank of hardware event counters for a memory-side agent. Each counter has an 8-bit event code that picks one line of a 256-wide vector of single-cycle event pulses. A counter advances by one on each cycle in which its selected pulse is high, provided that three conditions hold: the global run bit is set, the counter's own enable bit is set, and the request-source qualifiers accept the current request. When a counter passes its all-ones value it wraps to zero and raises a per-counter overflow status bit. The status bits, after the interrupt mask is applied, are ORed into one interrupt line.

Software reaches the bank through a simple 32-bit register port made of address, write strobe, write data and registered read data. A parallel 64-bit data path on the same address reads and loads whole counters. A build-time version parameter sets the shape of the bank. Version 1 gives sixteen 48-bit counters. Version 2 or above gives eight 64-bit counters. Software can read the version value back.

Register map (byte addresses): interrupt mask 0x00, interrupt status 0x04, interrupt clear 0x08, version 0x0C, run control 0x10, counter enable 0x14, source filter 0x18, data-source control 0x1C, event select registers from 0x40 in steps of 4, and counters from 0x100 in steps of 8.

Top module: `evctr_bank`

## Requirements
- R1: The parameter VERSION chooses the bank shape. VERSION < 2 gives 16 counters of 48 bits. Otherwise the bank has 8 counters of 64 bits. A read of address 0x0C returns VERSION.
- R2: In the 48-bit shape, bits 63:48 of a counter read as zero, and a 64-bit load discards them.
- R3: Counter n is read on wide_rdata and loaded from wide_wdata by wide_we at address 0x100 + 8*n. A load takes priority over an increment in the same cycle.
- R4: Event select register k sits at 0x40 + 4*k. It holds the codes of counters 4k..4k+3, and counter n's code is at bits 8*(n%4)+7 : 8*(n%4). Code 0xFF selects nothing, so the counter stays put. Every select byte resets to 0xFF.
- R5: A counter increments only when bit 0 of run control (0x10) and bit n of counter enable (0x14) are both 1.
- R6: The source filter register (0x18) has an enable at bit 2, a command at bits 16:6, a mask at bits 30:20 and a trace-tag bit at bit 31. When the filter is enabled, an event counts only if (req_cmd & ~mask) == (cmd & ~mask).
- R7: Interrupt mask bit n = 0 lets counter n's overflow reach irq, and a 1 masks it. The mask resets to all ones. irq is a register holding the OR of status & ~mask, so it follows status and mask by one cycle.
- R8: In the cycle that a counter wraps from all ones to zero, status bit n (0x04) is set. Writing 1 to bit n of 0x08 clears status bit n. If an overflow and a clear fall in the same cycle, the overflow wins.
- R9: Bit 23 of data-source control (0x1C) set to 1 limits counting to cycles with req_socket = 1. This bit never enables a counter by itself.
- R10: Register reads are registered. bus_rdata and wide_rdata show the value at bus_addr one clock edge after the address is applied. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register or counter |
| bus_we | input | 1 | 32-bit register write strobe |
| bus_wdata | input | 32 | 32-bit write data |
| bus_rdata | output | 32 | Registered 32-bit read data |
| wide_we | input | 1 | 64-bit counter load strobe |
| wide_wdata | input | 64 | Counter load value |
| wide_rdata | output | 64 | Registered counter read value, zero-extended |
| evt_i | input | 256 | Event pulses, one line per event code |
| req_cmd | input | 11 | Command of the current request, compared by the source filter |
| req_socket | input | 1 | Current request is sourced from the socket |
| irq | output | 1 | Overflow interrupt |

## Verification
An event pulse that is high across a rising edge is counted at that edge. A register write takes effect at the edge where the strobe is high. A read value appears one edge after its address is applied. For this reason the bench drives every input on the falling edge and reads results on the next falling edge, after the single edge that updates them. irq needs one more edge than status and mask, because it is a register fed by them. The bench therefore waits an extra falling edge before it checks irq after an overflow, a mask write or a clear. Counter values are checked only after the event window is closed and at least one further edge has passed. This way each read sees the complete count.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
  localparam int A_MASK = 'h000;
  localparam int A_STAT = 'h004;
  localparam int A_CLR  = 'h008;
  localparam int A_VER  = 'h00C;
  localparam int A_GCTL = 'h010;
  localparam int A_CEN  = 'h014;
  localparam int A_FLT  = 'h018;
  localparam int A_DSRC = 'h01C;
  localparam int A_SEL0 = 'h040;
  localparam int A_CNT0 = 'h100;

  localparam int CODE_W    = 8;
  localparam logic [7:0] CODE_NONE = 8'hFF;

  function automatic int cnt_num(input int ver);
    return (ver >= 2) ? 8 : 16;
  endfunction

  function automatic int cnt_width(input int ver);
    return (ver >= 2) ? 64 : 48;
  endfunction
endpackage

// File: rtl/evctr_filter.sv
module evctr_filter #(
  parameter int CMD_W = 11
) (
  input  logic             flt_en,
  input  logic [CMD_W-1:0] flt_cmd,
  input  logic [CMD_W-1:0] flt_msk,
  input  logic             dsrc_skt,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic             req_socket,
  output logic             pass
);
  logic cmd_ok;
  logic src_ok;

  always_comb begin
    cmd_ok = !flt_en || (((req_cmd ^ flt_cmd) & ~flt_msk) == '0);
    src_ok = !dsrc_skt || req_socket;
    pass   = cmd_ok && src_ok;
  end
endmodule

// File: rtl/evctr_counter.sv
module evctr_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (wr_en) count <= wr_data;
    else if (inc)   count <= count + 1'b1;
  end

  assign ovf = inc && !wr_en && (&count);
endmodule

// File: rtl/evctr_bank.sv
module evctr_bank #(
  parameter int VERSION = 1,
  parameter int ADDR_W  = 12,
  parameter int CMD_W   = 11,
  parameter int N_EVT   = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              wide_we,
  input  logic [63:0]       wide_wdata,
  output logic [63:0]       wide_rdata,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic              req_socket,
  output logic              irq
);
  import evctr_pkg::*;

  localparam int N_CNT  = cnt_num(VERSION);
  localparam int CNT_W  = cnt_width(VERSION);
  localparam int N_SEL  = N_CNT / 4;
  localparam int IDX_W  = $clog2(N_CNT);
  localparam int SEL_IW = (N_SEL > 1) ? $clog2(N_SEL) : 1;

  // control state
  logic             glob_en;
  logic [N_CNT-1:0] cnt_en;
  logic [N_CNT-1:0] irq_mask;
  logic [N_CNT-1:0] irq_stat;
  logic             flt_en;
  logic             trace_en;
  logic [CMD_W-1:0] flt_cmd;
  logic [CMD_W-1:0] flt_msk;
  logic             dsrc_skt;
  logic [31:0]      evsel [N_SEL];

  // address decode
  logic [3:0]        cidx;
  logic [1:0]        sidx;
  logic              cnt_hit;
  logic              sel_hit;
  logic [IDX_W-1:0]  cnum;
  logic [SEL_IW-1:0] snum;

  assign cidx    = bus_addr[6:3];
  assign sidx    = bus_addr[3:2];
  assign cnum    = cidx[IDX_W-1:0];
  assign snum    = sidx[SEL_IW-1:0];
  assign cnt_hit = (bus_addr[ADDR_W-1:7] == (ADDR_W-7)'(A_CNT0 >> 7)) &&
                   (32'(cidx) < N_CNT) && (bus_addr[2:0] == 3'b000);
  assign sel_hit = (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(A_SEL0 >> 4)) &&
                   (32'(sidx) < N_SEL) && (bus_addr[1:0] == 2'b00);

  logic clr_hit;
  logic [N_CNT-1:0] clr_bits;
  assign clr_hit  = bus_we && (bus_addr == ADDR_W'(A_CLR));
  assign clr_bits = clr_hit ? bus_wdata[N_CNT-1:0] : '0;

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en  <= 1'b0;
      cnt_en   <= '0;
      irq_mask <= '1;
      flt_en   <= 1'b0;
      trace_en <= 1'b0;
      flt_cmd  <= '0;
      flt_msk  <= '0;
      dsrc_skt <= 1'b0;
      for (int k = 0; k < N_SEL; k++) evsel[k] <= '1;
    end else if (bus_we) begin
      case (bus_addr)
        ADDR_W'(A_MASK): irq_mask <= bus_wdata[N_CNT-1:0];
        ADDR_W'(A_GCTL): glob_en  <= bus_wdata[0];
        ADDR_W'(A_CEN):  cnt_en   <= bus_wdata[N_CNT-1:0];
        ADDR_W'(A_FLT): begin
          flt_en   <= bus_wdata[2];
          flt_cmd  <= bus_wdata[6 +: CMD_W];
          flt_msk  <= bus_wdata[20 +: CMD_W];
          trace_en <= bus_wdata[31];
        end
        ADDR_W'(A_DSRC): dsrc_skt <= bus_wdata[23];
        default: ;
      endcase
      if (sel_hit) evsel[snum] <= bus_wdata;
    end
  end

  // qualification shared by all counters
  logic src_pass;

  evctr_filter #(.CMD_W(CMD_W)) u_filter (
    .flt_en    (flt_en),
    .flt_cmd   (flt_cmd),
    .flt_msk   (flt_msk),
    .dsrc_skt  (dsrc_skt),
    .req_cmd   (req_cmd),
    .req_socket(req_socket),
    .pass      (src_pass)
  );

  // counters
  logic [CNT_W-1:0]       cnt_q [N_CNT];
  logic [N_CNT-1:0]       ovf_vec;
  logic [N_CNT*CNT_W-1:0] cnt_flat;

  for (genvar n = 0; n < N_CNT; n++) begin : g_cnt
    logic [CODE_W-1:0] code;
    logic              hit;
    logic              inc;
    logic              ld;

    assign code = evsel[n / 4][8 * (n % 4) +: CODE_W];
    assign hit  = (code != CODE_NONE) && evt_i[code];
    assign inc  = glob_en && cnt_en[n] && hit && src_pass;
    assign ld   = wide_we && cnt_hit && (cnum == IDX_W'(n));

    evctr_counter #(.CNT_W(CNT_W)) u_counter (
      .clk    (clk),
      .rst    (rst),
      .inc    (inc),
      .wr_en  (ld),
      .wr_data(wide_wdata[CNT_W-1:0]),
      .count  (cnt_q[n]),
      .ovf    (ovf_vec[n])
    );

    assign cnt_flat[n*CNT_W +: CNT_W] = cnt_q[n];
  end

  // overflow status and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_stat <= '0;
      irq      <= 1'b0;
    end else begin
      irq_stat <= (irq_stat & ~clr_bits) | ovf_vec;
      irq      <= |(irq_stat & ~irq_mask);
    end
  end

  // registered read path
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(A_MASK): rd_mux = 32'(irq_mask);
      ADDR_W'(A_STAT): rd_mux = 32'(irq_stat);
      ADDR_W'(A_VER):  rd_mux = 32'(VERSION);
      ADDR_W'(A_GCTL): rd_mux = {31'b0, glob_en};
      ADDR_W'(A_CEN):  rd_mux = 32'(cnt_en);
      ADDR_W'(A_FLT): begin
        rd_mux[2]            = flt_en;
        rd_mux[6 +: CMD_W]   = flt_cmd;
        rd_mux[20 +: CMD_W]  = flt_msk;
        rd_mux[31]           = trace_en;
      end
      ADDR_W'(A_DSRC): rd_mux[23] = dsrc_skt;
      default: ;
    endcase
    if (sel_hit) rd_mux = evsel[snum];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      wide_rdata <= '0;
    end else begin
      bus_rdata  <= rd_mux;
      wide_rdata <= cnt_hit ? 64'(cnt_q[cnum]) : 64'd0;
    end
  end
endmodule

// File: rtl/evctr_bank_chk.sv
module evctr_bank_chk #(
  parameter int N_CNT  = 16,
  parameter int CNT_W  = 48,
  parameter int ADDR_W = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   glob_en,
  input logic                   bus_we,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic                   wide_we,
  input logic [N_CNT*CNT_W-1:0] cnt_flat,
  input logic [N_CNT-1:0]       irq_stat,
  input logic [N_CNT-1:0]       irq_mask,
  input logic                   irq,
  input logic [63:0]            wide_rdata
);
  logic clr_wr;
  assign clr_wr = bus_we && (bus_addr == ADDR_W'(evctr_pkg::A_CLR));

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!glob_en && !wide_we) |=> $stable(cnt_flat)); // R5

  AST_IRQ_QUIET_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (irq_mask == {N_CNT{1'b1}}) |=> !irq); // R7

  AST_CLEAR_DROPS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !glob_en) |=> ((irq_stat & $past(bus_wdata[N_CNT-1:0])) == '0)); // R8

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!glob_en && !clr_wr) |=> $stable(irq_stat)); // R8

  AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((wide_rdata >> CNT_W) == 64'd0)); // R2
endmodule

bind evctr_bank evctr_bank_chk #(.N_CNT(N_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .glob_en   (glob_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .wide_we   (wide_we),
  .cnt_flat  (cnt_flat),
  .irq_stat  (irq_stat),
  .irq_mask  (irq_mask),
  .irq       (irq),
  .wide_rdata(wide_rdata)
);

// File: tb/evctr_bank_tb.sv
module evctr_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] R_MASK = 12'h000, R_STAT = 12'h004, R_CLR = 12'h008,
                          R_VER = 12'h00C, R_GCTL = 12'h010, R_CEN = 12'h014,
                          R_FLT = 12'h018, R_DSRC = 12'h01C, R_SEL = 12'h040,
                          R_CNT = 12'h100;

  logic         clk = 0;
  logic         rst = 1;
  logic [11:0]  bus_addr = '0;
  logic         bus_we = 0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         wide_we = 0;
  logic [63:0]  wide_wdata = '0;
  logic [63:0]  wide_rdata;
  logic [255:0] evt_i = '0;
  logic [10:0]  req_cmd = '0;
  logic         req_socket = 0;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evctr_bank u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wide_we(wide_we),
    .wide_wdata(wide_wdata), .wide_rdata(wide_rdata), .evt_i(evt_i),
    .req_cmd(req_cmd), .req_socket(req_socket), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic wr64(input int n, input logic [63:0] d);
    @(negedge clk); bus_addr = R_CNT + 12'(8*n); wide_wdata = d; wide_we = 1;
    @(negedge clk); wide_we = 0;
  endtask

  task automatic rd64(input int n, output logic [63:0] d);
    @(negedge clk); bus_addr = R_CNT + 12'(8*n);
    @(negedge clk); d = wide_rdata;
  endtask

  task automatic pulse(input int code, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); evt_i = '0; evt_i[code] = 1'b1;
    end
    @(negedge clk); evt_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd32(R_MASK, d); chk("R7 mask reset", 64'(d), 64'h0000FFFF);
    rd32(R_STAT, d); chk("R8 status reset", 64'(d), 64'h0);
    rd32(R_VER, d);  chk("R1 version", 64'(d), 64'h1);
    rd32(R_SEL, d);  chk("R4 select reset", 64'(d), 64'hFFFFFFFF);
    rd32(12'h3F0, d); chk("R10 unmapped", 64'(d), 64'h0);
    chk("R7 irq reset", 64'(irq), 64'h0);
  endtask

  task automatic t_basic();
    logic [63:0] q;
    wr32(R_SEL, 32'hFFFFFF05);
    wr32(R_CEN, 32'h1);
    pulse(5, 4);
    rd64(0, q); chk("R5 no count while run bit off", q, 64'd0);
    wr32(R_GCTL, 32'h1);
    pulse(5, 10);
    rd64(0, q); chk("R5 count with both enables", q, 64'd10);
    wr32(R_CEN, 32'h0);
    pulse(5, 3);
    rd64(0, q); chk("R5 no count with counter bit off", q, 64'd10);
  endtask

  task automatic t_select();
    logic [63:0] q;
    wr32(R_CEN, 32'h0042);           // counters 1 and 6
    wr32(R_SEL + 12'h4, 32'hFF23FFFF); // counter 6 -> code 0x23
    pulse(8'h23, 3);
    rd64(6, q); chk("R4 counter 6 packed code", q, 64'd3);
    rd64(0, q); chk("R4 counter 0 unaffected", q, 64'd10);
    pulse(255, 4);
    rd64(1, q); chk("R4 code FF does not count", q, 64'd0);
  endtask

  task automatic t_wide();
    logic [63:0] q;
    wr64(2, 64'hFFFF_0000_0000_0001);
    rd64(2, q); chk("R2 upper bits ignored", q, 64'h1);
    wr64(15, 64'h0000_1234_5678_9ABC);
    rd64(15, q); chk("R3 counter 15 at base+0x78", q, 64'h0000_1234_5678_9ABC);
  endtask

  task automatic t_overflow();
    logic [63:0] q;
    logic [31:0] d;
    wr32(R_SEL, 32'h07FFFF05);       // counter 3 -> code 7
    wr64(3, 64'h0000_FFFF_FFFF_FFFF);
    wr32(R_CEN, 32'h0008);
    pulse(7, 1);
    rd64(3, q); chk("R8 wrap to zero", q, 64'd0);
    rd32(R_STAT, d); chk("R8 status set", 64'(d), 64'h8);
    chk("R7 masked overflow keeps irq low", 64'(irq), 64'h0);
    wr32(R_MASK, 32'h0000FFF7);
    @(negedge clk);
    chk("R7 unmasked overflow raises irq", 64'(irq), 64'h1);
    wr32(R_CLR, 32'h8);
    rd32(R_STAT, d); chk("R8 clear status", 64'(d), 64'h0);
    chk("R7 irq drops after clear", 64'(irq), 64'h0);
    wr32(R_MASK, 32'h0000FFFF);
  endtask

  task automatic t_filter();
    logic [63:0] q;
    logic [31:0] d;
    wr64(0, 64'd0);
    wr32(R_CEN, 32'h1);
    wr32(R_FLT, (32'h1 << 2) | (32'h123 << 6) | (32'h00F << 20));
    rd32(R_FLT, d); chk("R6 filter readback", 64'(d), 64'((32'h1 << 2) | (32'h123 << 6) | (32'h00F << 20)));
    req_cmd = 11'h12A;
    pulse(5, 2);
    rd64(0, q); chk("R6 matching command counts", q, 64'd2);
    req_cmd = 11'h133;
    pulse(5, 2);
    rd64(0, q); chk("R6 mismatching command blocked", q, 64'd2);
    wr32(R_FLT, 32'h0);
    pulse(5, 1);
    rd64(0, q); chk("R6 filter off counts all", q, 64'd3);
  endtask

  task automatic t_dsrc();
    logic [63:0] q;
    wr32(R_CEN, 32'h0);
    wr32(R_DSRC, 32'h0080_0000);
    req_socket = 1;
    pulse(5, 2);
    rd64(0, q); chk("R9 bit 23 is not an enable", q, 64'd3);
    wr32(R_CEN, 32'h1);
    req_socket = 0;
    pulse(5, 2);
    rd64(0, q); chk("R9 non-socket request blocked", q, 64'd3);
    req_socket = 1;
    pulse(5, 2);
    rd64(0, q); chk("R9 socket request counts", q, 64'd5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_basic();
    t_select();
    t_wide();
    t_overflow();
    t_filter();
    t_dsrc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule